// File: doc/BRIEF.md
# Serial Game Command Parser

This block sits behind a UART receiver and turns a stream of ASCII bytes into decoded commands for a board game engine. Each byte arrives with a one-cycle valid qualifier. The block collects the bytes of one line and decides what the line means when the line terminator arrives. The grammar is small. A placement line names a mark (X or O), then a row digit, then a column digit, with spaces between the tokens. The single letters M, S and E ask for the menu, a new game and an exit.

The engine and the user-feedback logic do not see any bytes. They see one single-cycle strobe per decoded line: place, menu, new, exit or invalid. The mark, row and column of the latest placement sit on registered outputs. Those outputs change only when a new placement strobe fires, so the engine may sample them in that cycle or in any later one. Any line that breaks the grammar raises the invalid strobe once, on its terminator. The parser then starts afresh on the next line.

Top module: `cmd_line_parser`

## Requirements
- R1: While reset is low and in the first cycle after it, all five strobes are low, the mark output is 0 and the row and column outputs are 0.
- R2: A line made of the mark letter, a row digit and a column digit, then a terminator, raises place_stb for one cycle. The strobe comes in the cycle after the terminator byte is accepted. place_mark is 0 for X (0x58) and 1 for O (0x4F). place_row and place_col carry the digit value: '1' (0x31) gives 1, up to '3'.
- R3: Tokens are separated by one or more spaces (0x20), and spaces before the first token or after the last one are allowed. A missing separator, as in "X11" or "O2 2", makes the line invalid.
- R4: A line holding only the letter M (0x4D) raises menu_stb. A line holding only S (0x53) raises new_stb. A line holding only E (0x45) raises exit_stb. Each strobe comes one cycle after the terminator.
- R5: The lowercase letters x, o, m, s and e (upper-case code plus 0x20) are decoded exactly like their uppercase forms.
- R6: A row or column digit outside '1' to '3' (for example '0', '4' or '9') makes the line invalid.
- R7: Every line that is not empty and does not match the grammar raises invalid_stb exactly once, one cycle after its terminator. This covers unknown letters, extra characters, extra tokens and missing tokens. The next line is decoded normally.
- R8: Both CR (0x0D) and LF (0x0A) end a line. A line that is empty or holds only spaces raises no strobe, so a CR followed by LF yields a single strobe.
- R9: At most one strobe is high in any cycle. A strobe is never high in two consecutive cycles. A strobe is high only in the cycle after a byte was accepted.
- R10: place_mark, place_row and place_col change only in a cycle where place_stb is high, and hold their values otherwise.
- R11: When rx_valid is low, rx_data has no effect on the outputs or on the parse in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | rx_data holds a received byte this cycle |
| rx_data | input | 8 | Received ASCII byte |
| place_stb | output | 1 | One-cycle strobe: placement decoded |
| place_mark | output | 1 | Mark of the last placement, 0 = X, 1 = O |
| place_row | output | 2 | Row of the last placement, 1 to 3 |
| place_col | output | 2 | Column of the last placement, 1 to 3 |
| menu_stb | output | 1 | One-cycle strobe: menu requested |
| new_stb | output | 1 | One-cycle strobe: new game requested |
| exit_stb | output | 1 | One-cycle strobe: exit requested |
| invalid_stb | output | 1 | One-cycle strobe: malformed line |

## Verification
Every result of this block is due exactly one clock after the rising edge that accepts the terminator byte. No other byte causes any output to change. The bench keeps a reference model that gathers the line in a queue and tokenises it. On the same rising edge that accepts the terminator, the model decides the expected strobe and fields. The bench then compares all outputs at the following falling edge, on every cycle, so a strobe that comes early, comes late or lasts two cycles shows up as a mismatch. Idle cycles drive terminator and letter codes on rx_data with rx_valid low, so bytes that must be ignored are probed during the same comparisons.

// File: rtl/cmd_parse_pkg.sv
// Package: shared character codes, token classes, parser events and states
// for the serial game command parser. Assumes 8-bit ASCII input.
package cmd_parse_pkg;

    localparam logic [7:0] ASC_CR   = 8'h0D;
    localparam logic [7:0] ASC_LF   = 8'h0A;
    localparam logic [7:0] ASC_SP   = 8'h20;
    localparam logic [7:0] ASC_ZERO = 8'h30;
    localparam logic [7:0] ASC_X    = 8'h58;
    localparam logic [7:0] ASC_O    = 8'h4F;
    localparam logic [7:0] ASC_M    = 8'h4D;
    localparam logic [7:0] ASC_S    = 8'h53;
    localparam logic [7:0] ASC_E    = 8'h45;
    localparam logic [7:0] ASC_LA   = 8'h61;
    localparam logic [7:0] ASC_LZ   = 8'h7A;
    localparam logic [7:0] CASE_BIT = 8'h20;

    // Class of one received byte after case folding.
    typedef enum logic [3:0] {
        CC_OTHER,
        CC_TERM,
        CC_SPACE,
        CC_MARK_X,
        CC_MARK_O,
        CC_MENU,
        CC_NEW,
        CC_EXIT,
        CC_DIGIT
    } char_cls_e;

    // Decoded outcome of a completed line.
    typedef enum logic [2:0] {
        EV_NONE,
        EV_PLACE,
        EV_MENU,
        EV_NEW,
        EV_EXIT,
        EV_BAD
    } cmd_ev_e;

    // Position of the parser inside the current line.
    typedef enum logic [2:0] {
        ST_LINE,   // at line start, nothing but spaces seen
        ST_CTRL,   // single control letter seen
        ST_MARK,   // mark letter seen, separator required
        ST_GAP1,   // separator after mark, row digit required
        ST_ROW,    // row digit seen, separator required
        ST_GAP2,   // separator after row, column digit required
        ST_COL,    // full placement seen, only spaces or terminator
        ST_DROP    // line already malformed, wait for terminator
    } parse_st_e;

endpackage

// File: rtl/cmd_char_class.sv
// Module: cmd_char_class
// Classifies one received byte into a token class for the parser FSM.
// Folds lowercase letters to uppercase when LOWER_OK is set. A digit is
// reported as CC_DIGIT only when it lies in '1'..BOARD_N; any other digit
// falls into CC_OTHER. Assumes 1 <= BOARD_N <= 9. Purely combinational.
module cmd_char_class
    import cmd_parse_pkg::*;
#(
    parameter int BOARD_N  = 3,
    parameter bit LOWER_OK = 1'b1,
    parameter int COORD_W  = 2
) (
    input  logic [7:0]         byte_i,
    output char_cls_e          cls_o,
    output logic [COORD_W-1:0] digit_o
);

    localparam logic [7:0] DIG_LO = ASC_ZERO + 8'd1;
    localparam logic [7:0] DIG_HI = 8'(int'(ASC_ZERO) + BOARD_N);

    logic [7:0] up;

    // Case folding variant picked by parameter.
    generate
        if (LOWER_OK) begin : g_fold
            // Map 'a'..'z' onto 'A'..'Z', pass everything else unchanged.
            always_comb begin
                if (byte_i >= ASC_LA && byte_i <= ASC_LZ) begin
                    up = byte_i - CASE_BIT;
                end else begin
                    up = byte_i;
                end
            end
        end else begin : g_exact
            assign up = byte_i;
        end
    endgenerate

    // Assign the token class of the folded byte.
    always_comb begin
        case (up)
            ASC_CR, ASC_LF: cls_o = CC_TERM;
            ASC_SP:         cls_o = CC_SPACE;
            ASC_X:          cls_o = CC_MARK_X;
            ASC_O:          cls_o = CC_MARK_O;
            ASC_M:          cls_o = CC_MENU;
            ASC_S:          cls_o = CC_NEW;
            ASC_E:          cls_o = CC_EXIT;
            default: begin
                if (up >= DIG_LO && up <= DIG_HI) begin
                    cls_o = CC_DIGIT;
                end else begin
                    cls_o = CC_OTHER;
                end
            end
        endcase
    end

    assign digit_o = COORD_W'(up[3:0]);

    // R6: a byte classed as a digit always carries a board coordinate.
    always_comb begin
        if (cls_o == CC_DIGIT) begin
            a_r6_digit_range: assert (digit_o >= COORD_W'(1) && digit_o <= COORD_W'(BOARD_N))
                else $error("digit class with coordinate %0d", digit_o);
        end
    end

endmodule

// File: rtl/cmd_parse_fsm.sv
// Module: cmd_parse_fsm
// Line-level parser. Walks the grammar one accepted byte at a time and
// holds the pending mark, row, column and control command. On a terminator
// it reports the event for the line (combinationally, in the cycle the
// terminator is presented) and returns to line start. Assumes the byte
// class comes from cmd_char_class and is only meaningful when valid_i is high.
module cmd_parse_fsm
    import cmd_parse_pkg::*;
#(
    parameter int COORD_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  char_cls_e          cls_i,
    input  logic [COORD_W-1:0] digit_i,
    output cmd_ev_e            ev_o,
    output logic               mark_o,
    output logic [COORD_W-1:0] row_o,
    output logic [COORD_W-1:0] col_o
);

    parse_st_e          st_q, st_d;
    cmd_ev_e            ctrl_q, ctrl_d;
    logic               mark_q, mark_d;
    logic [COORD_W-1:0] row_q, row_d;
    logic [COORD_W-1:0] col_q, col_d;

    // Next state, captures and line event for the presented byte.
    always_comb begin
        st_d   = st_q;
        ctrl_d = ctrl_q;
        mark_d = mark_q;
        row_d  = row_q;
        col_d  = col_q;
        ev_o   = EV_NONE;
        if (valid_i) begin
            case (st_q)
                ST_LINE: begin
                    case (cls_i)
                        CC_TERM, CC_SPACE: st_d = ST_LINE;
                        CC_MARK_X: begin mark_d = 1'b0; st_d = ST_MARK; end
                        CC_MARK_O: begin mark_d = 1'b1; st_d = ST_MARK; end
                        CC_MENU:   begin ctrl_d = EV_MENU; st_d = ST_CTRL; end
                        CC_NEW:    begin ctrl_d = EV_NEW;  st_d = ST_CTRL; end
                        CC_EXIT:   begin ctrl_d = EV_EXIT; st_d = ST_CTRL; end
                        default:   st_d = ST_DROP;
                    endcase
                end
                ST_CTRL: begin
                    case (cls_i)
                        CC_TERM:  begin ev_o = ctrl_q; st_d = ST_LINE; end
                        CC_SPACE: st_d = ST_CTRL;
                        default:  st_d = ST_DROP;
                    endcase
                end
                ST_MARK: begin
                    case (cls_i)
                        CC_TERM:  begin ev_o = EV_BAD; st_d = ST_LINE; end
                        CC_SPACE: st_d = ST_GAP1;
                        default:  st_d = ST_DROP;
                    endcase
                end
                ST_GAP1: begin
                    case (cls_i)
                        CC_TERM:  begin ev_o = EV_BAD; st_d = ST_LINE; end
                        CC_SPACE: st_d = ST_GAP1;
                        CC_DIGIT: begin row_d = digit_i; st_d = ST_ROW; end
                        default:  st_d = ST_DROP;
                    endcase
                end
                ST_ROW: begin
                    case (cls_i)
                        CC_TERM:  begin ev_o = EV_BAD; st_d = ST_LINE; end
                        CC_SPACE: st_d = ST_GAP2;
                        default:  st_d = ST_DROP;
                    endcase
                end
                ST_GAP2: begin
                    case (cls_i)
                        CC_TERM:  begin ev_o = EV_BAD; st_d = ST_LINE; end
                        CC_SPACE: st_d = ST_GAP2;
                        CC_DIGIT: begin col_d = digit_i; st_d = ST_COL; end
                        default:  st_d = ST_DROP;
                    endcase
                end
                ST_COL: begin
                    case (cls_i)
                        CC_TERM:  begin ev_o = EV_PLACE; st_d = ST_LINE; end
                        CC_SPACE: st_d = ST_COL;
                        default:  st_d = ST_DROP;
                    endcase
                end
                default: begin
                    if (cls_i == CC_TERM) begin
                        ev_o = EV_BAD;
                        st_d = ST_LINE;
                    end
                end
            endcase
        end
    end

    // Parser state and pending fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_LINE;
            ctrl_q <= EV_NONE;
            mark_q <= 1'b0;
            row_q  <= '0;
            col_q  <= '0;
        end else begin
            st_q   <= st_d;
            ctrl_q <= ctrl_d;
            mark_q <= mark_d;
            row_q  <= row_d;
            col_q  <= col_d;
        end
    end

    assign mark_o = mark_q;
    assign row_o  = row_q;
    assign col_o  = col_q;

    // R11: without a valid byte the parse position does not move.
    a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(st_q))
        else $error("parser state moved without a valid byte");

    // R7: a malformed line stays discarded until its terminator.
    a_r7_drop_until_term: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DROP && valid_i && cls_i != CC_TERM) |=> st_q == ST_DROP)
        else $error("left discard state before terminator");

    // R8: a terminator always brings the parser back to line start.
    a_r8_term_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && cls_i == CC_TERM) |=> st_q == ST_LINE)
        else $error("terminator did not restart the line");

endmodule

// File: rtl/cmd_strobe_reg.sv
// Module: cmd_strobe_reg
// Output stage. Registers the line event into one-hot single-cycle strobes
// and captures the placement fields only when a placement is decoded, so
// the fields hold between placements. Assumes ev_i is EV_NONE unless a
// terminator byte is presented with valid_i high.
module cmd_strobe_reg
    import cmd_parse_pkg::*;
#(
    parameter int BOARD_N = 3,
    parameter int COORD_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  cmd_ev_e            ev_i,
    input  logic               mark_i,
    input  logic [COORD_W-1:0] row_i,
    input  logic [COORD_W-1:0] col_i,
    output logic               place_o,
    output logic               mark_o,
    output logic [COORD_W-1:0] row_o,
    output logic [COORD_W-1:0] col_o,
    output logic               menu_o,
    output logic               new_o,
    output logic               exit_o,
    output logic               bad_o
);

    // Strobe decode and placement field capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            place_o <= 1'b0;
            menu_o  <= 1'b0;
            new_o   <= 1'b0;
            exit_o  <= 1'b0;
            bad_o   <= 1'b0;
            mark_o  <= 1'b0;
            row_o   <= '0;
            col_o   <= '0;
        end else begin
            place_o <= (ev_i == EV_PLACE);
            menu_o  <= (ev_i == EV_MENU);
            new_o   <= (ev_i == EV_NEW);
            exit_o  <= (ev_i == EV_EXIT);
            bad_o   <= (ev_i == EV_BAD);
            if (ev_i == EV_PLACE) begin
                mark_o <= mark_i;
                row_o  <= row_i;
                col_o  <= col_i;
            end
        end
    end

    // R9: never two strobes in one cycle.
    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({place_o, menu_o, new_o, exit_o, bad_o}))
        else $error("more than one strobe high");

    // R9: a strobe lasts one cycle.
    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (place_o || menu_o || new_o || exit_o || bad_o)
        |=> !(place_o || menu_o || new_o || exit_o || bad_o))
        else $error("strobe held for two cycles");

    // R9: a strobe follows an accepted byte.
    a_r9_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (place_o || menu_o || new_o || exit_o || bad_o) |-> $past(valid_i))
        else $error("strobe without a preceding byte");

    // R10: placement fields move only together with a placement strobe.
    a_r10_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !place_o |-> $stable({mark_o, row_o, col_o}))
        else $error("placement fields changed without strobe");

    // R2: a placement carries board coordinates.
    a_r2_coord_range: assert property (@(posedge clk) disable iff (!rst_n)
        place_o |-> (row_o >= COORD_W'(1) && row_o <= COORD_W'(BOARD_N)
                     && col_o >= COORD_W'(1) && col_o <= COORD_W'(BOARD_N)))
        else $error("placement outside the board");

endmodule

// File: rtl/cmd_line_parser.sv
// Module: cmd_line_parser (top)
// Serial game command parser: byte classifier, line FSM and strobe output
// stage. Every decoded line yields one strobe one cycle after its
// terminator byte is accepted. Assumes a byte stream qualified by rx_valid
// and a square board of BOARD_N (1..9) rows and columns.
module cmd_line_parser
    import cmd_parse_pkg::*;
#(
    parameter int  BOARD_N  = 3,
    parameter bit  LOWER_OK = 1'b1,
    localparam int COORD_W  = $clog2(BOARD_N + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    output logic               place_stb,
    output logic               place_mark,
    output logic [COORD_W-1:0] place_row,
    output logic [COORD_W-1:0] place_col,
    output logic               menu_stb,
    output logic               new_stb,
    output logic               exit_stb,
    output logic               invalid_stb
);

    char_cls_e          cls;
    logic [COORD_W-1:0] digit;
    cmd_ev_e            ev;
    logic               pend_mark;
    logic [COORD_W-1:0] pend_row;
    logic [COORD_W-1:0] pend_col;

    cmd_char_class #(
        .BOARD_N  (BOARD_N),
        .LOWER_OK (LOWER_OK),
        .COORD_W  (COORD_W)
    ) u_class (
        .byte_i  (rx_data),
        .cls_o   (cls),
        .digit_o (digit)
    );

    cmd_parse_fsm #(
        .COORD_W (COORD_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (rx_valid),
        .cls_i   (cls),
        .digit_i (digit),
        .ev_o    (ev),
        .mark_o  (pend_mark),
        .row_o   (pend_row),
        .col_o   (pend_col)
    );

    cmd_strobe_reg #(
        .BOARD_N (BOARD_N),
        .COORD_W (COORD_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (rx_valid),
        .ev_i    (ev),
        .mark_i  (pend_mark),
        .row_i   (pend_row),
        .col_i   (pend_col),
        .place_o (place_stb),
        .mark_o  (place_mark),
        .row_o   (place_row),
        .col_o   (place_col),
        .menu_o  (menu_stb),
        .new_o   (new_stb),
        .exit_o  (exit_stb),
        .bad_o   (invalid_stb)
    );

endmodule

// File: tb/cmd_line_parser_tb_top.sv
// Bench for cmd_line_parser: behavioural line model (byte queue, tokeniser)
// compared against every output on every falling clock edge.
module cmd_line_parser_tb_top;

    localparam int WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       place_stb, place_mark, menu_stb, new_stb, exit_stb, invalid_stb;
    logic [1:0] place_row, place_col;

    int    compared   = 0;
    int    mismatched = 0;
    int    cycles     = 0;
    bit    done       = 1'b0;
    bit    checking   = 1'b0;
    string cur_req    = "R1";

    // Model state.
    byte unsigned line_q[$];
    logic [4:0]   exp_stb;      // {place, menu, new, exit, invalid}
    logic         exp_mark;
    logic [1:0]   exp_row, exp_col;
    logic [7:0]   idle_junk = 8'h0D;

    always #5 clk = ~clk;

    cmd_line_parser dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .place_stb   (place_stb),
        .place_mark  (place_mark),
        .place_row   (place_row),
        .place_col   (place_col),
        .menu_stb    (menu_stb),
        .new_stb     (new_stb),
        .exit_stb    (exit_stb),
        .invalid_stb (invalid_stb)
    );

    // Tokenise a line: 0 none, 1 place, 2 menu, 3 new, 4 exit, 5 invalid.
    function automatic void decode(input byte unsigned ln[$], output int ev,
                                   output bit m, output int r, output int c);
        int           tl[$];
        byte unsigned tc[$];
        int           cur = 0;
        ev = 0; m = 1'b0; r = 0; c = 0;
        foreach (ln[i]) begin
            byte unsigned b = ln[i];
            if (b >= 8'h61 && b <= 8'h7A) b = b - 8'h20;
            if (b == 8'h20) begin
                if (cur > 0) begin tl.push_back(cur); cur = 0; end
            end else begin
                if (cur == 0) tc.push_back(b);
                cur++;
            end
        end
        if (cur > 0) tl.push_back(cur);
        if (tl.size() == 0) begin
            ev = 0;
        end else if (tl.size() == 1 && tl[0] == 1 && tc[0] == 8'h4D) begin
            ev = 2;
        end else if (tl.size() == 1 && tl[0] == 1 && tc[0] == 8'h53) begin
            ev = 3;
        end else if (tl.size() == 1 && tl[0] == 1 && tc[0] == 8'h45) begin
            ev = 4;
        end else if (tl.size() == 3 && tl[0] == 1 && tl[1] == 1 && tl[2] == 1
                     && (tc[0] == 8'h58 || tc[0] == 8'h4F)
                     && tc[1] >= 8'h31 && tc[1] <= 8'h33
                     && tc[2] >= 8'h31 && tc[2] <= 8'h33) begin
            ev = 1;
            m  = (tc[0] == 8'h4F);
            r  = tc[1] - 8'h30;
            c  = tc[2] - 8'h30;
        end else begin
            ev = 5;
        end
    endfunction

    // Reference model: advances on each rising edge from sampled inputs.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            exp_stb  = '0;
            exp_mark = 1'b0;
            exp_row  = '0;
            exp_col  = '0;
            line_q.delete();
        end else begin
            exp_stb = '0;
            if (rx_valid) begin
                if (rx_data == 8'h0D || rx_data == 8'h0A) begin
                    int ev, r, c;
                    bit m;
                    decode(line_q, ev, m, r, c);
                    case (ev)
                        1: begin
                            exp_stb  = 5'b10000;
                            exp_mark = m;
                            exp_row  = 2'(r);
                            exp_col  = 2'(c);
                        end
                        2: exp_stb = 5'b01000;
                        3: exp_stb = 5'b00100;
                        4: exp_stb = 5'b00010;
                        5: exp_stb = 5'b00001;
                        default: exp_stb = '0;
                    endcase
                    line_q.delete();
                end else begin
                    line_q.push_back(rx_data);
                end
            end
        end
    end

    // Compare every output against the model away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && checking) begin
            logic [4:0] got;
            got = {place_stb, menu_stb, new_stb, exit_stb, invalid_stb};
            compared++;
            if (got !== exp_stb ||
                {place_mark, place_row, place_col} !== {exp_mark, exp_row, exp_col}) begin
                mismatched++;
                if (got !== exp_stb)
                    $display("FAIL %s/R9 strobes {place,menu,new,exit,inv}: got %b exp %b",
                             cur_req, got, exp_stb);
                else
                    $display("FAIL %s/R10 fields {mark,row,col}: got %0d,%0d,%0d exp %0d,%0d,%0d",
                             cur_req, place_mark, place_row, place_col,
                             exp_mark, exp_row, exp_col);
            end
        end
    end

    // Present one byte; spacing idle cycles follow with junk on rx_data.
    task automatic put_byte(input logic [7:0] b, input int spacing);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        for (int k = 0; k < spacing; k++) begin
            @(negedge clk);
            rx_valid = 1'b0;
            rx_data  = idle_junk;
        end
    endtask

    // Present a line body, a terminator, then let the result settle.
    task automatic line(input string s, input logic [7:0] term, input int spacing);
        for (int i = 0; i < s.len(); i++) put_byte(s[i], spacing);
        put_byte(term, spacing);
        @(negedge clk);
        rx_valid = 1'b0;
        rx_data  = idle_junk;
        repeat (2) @(negedge clk);
    endtask

    initial begin : stim
        rst_n    = 1'b0;
        rx_valid = 1'b0;
        rx_data  = 8'h0D;
        repeat (3) @(negedge clk);
        // R1: outputs during reset.
        compared++;
        if ({place_stb, menu_stb, new_stb, exit_stb, invalid_stb,
             place_mark, place_row, place_col} !== 10'd0) begin
            mismatched++;
            $display("FAIL R1 reset outputs: got %b exp 0",
                     {place_stb, menu_stb, new_stb, exit_stb, invalid_stb,
                      place_mark, place_row, place_col});
        end
        rst_n = 1'b1;
        checking = 1'b1;
        repeat (2) @(negedge clk);

        cur_req = "R2";
        line("X 1 1", 8'h0D, 0);
        line("O 2 2", 8'h0A, 1);
        line("X 3 2", 8'h0D, 2);
        line("O 1 3", 8'h0D, 0);

        cur_req = "R3";
        line("  X   2  3  ", 8'h0D, 0);
        line("X11", 8'h0D, 0);
        line("O2 2", 8'h0A, 1);
        line("X 1  1 ", 8'h0D, 0);
        line("O 3 1", 8'h0D, 0);

        cur_req = "R4";
        line("M", 8'h0D, 0);
        line("S", 8'h0A, 1);
        line(" E ", 8'h0D, 0);

        cur_req = "R5";
        line("x 3 3", 8'h0D, 0);
        line("o 1 2", 8'h0A, 0);
        line("m", 8'h0D, 1);
        line("s", 8'h0D, 0);
        line("e", 8'h0D, 0);

        cur_req = "R6";
        line("X 0 1", 8'h0D, 0);
        line("X 1 4", 8'h0D, 0);
        line("O 9 2", 8'h0D, 1);

        cur_req = "R7";
        line("MENU", 8'h0D, 0);
        line("X 1 1 1", 8'h0D, 0);
        line("Q", 8'h0A, 0);
        line("X 1", 8'h0D, 0);
        line("X", 8'h0D, 0);
        line("E E", 8'h0D, 0);
        line("#", 8'h0D, 0);
        line("S", 8'h0D, 0);

        cur_req = "R8";
        line("M", 8'h0D, 0);
        line("", 8'h0A, 0);
        line("   ", 8'h0D, 0);
        line("O 2 1", 8'h0A, 0);
        line("", 8'h0D, 0);

        cur_req = "R11";
        idle_junk = 8'h4D;
        line("X 2 3", 8'h0D, 3);
        idle_junk = 8'h0D;
        line("E", 8'h0D, 4);
        idle_junk = 8'h20;
        line("M 1", 8'h0D, 2);

        cur_req = "R9";
        idle_junk = 8'h0D;
        line("S", 8'h0D, 0);
        line("X 3 3", 8'h0D, 0);
        line("E", 8'h0D, 0);
        repeat (4) @(negedge clk);
        done = 1'b1;
    end

    initial begin : watchdog
        while (!done && cycles < WATCHDOG) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: got %0d cycles exp completion", cycles);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule